// File: doc/BRIEF.md
# Indirect Index-to-Address Pattern Detector

This block learns how a stream of loaded index values relates to the cache misses that follow them, so that a gather of the form `data[index[i]]` can be predicted. A prefetch-table owner that is not yet trained sends each index value it loads, tagged with its own identity. The cache sends every miss address. For an owner's first index, the block records candidate base addresses for a few subsequent misses under each of four element scalings. For the owner's second index, it checks new misses against those candidates. When two different index values point back to the same base under the same scaling, the block reports that base and shift to the owner.

A small fully associative table holds one entry per owner under training. Only one entry listens to misses at a time. That entry is the one most recently allocated or given its second index. A candidate base is `miss - (index << s)` for s in {2, 3, 4, -3}. A negative s is an arithmetic right shift by its magnitude. The index is a signed two's-complement value. All candidates of the listening entry are compared in a single cycle.

Top module: `ipat_detector`

## Requirements
- R1: After reset, `hit_valid_o` is 0 and no entry is allocated.
- R2: An index from an owner with no entry allocates one, stores the value as the first index and makes that entry the listener. Each miss the listener receives before its second index records, into the next free slot, the four candidates `miss - scale(idx1, s)`. The shifts are s = 2, 3, 4, -3. The index is signed `IDX_W`-bit, and a negative s is an arithmetic right shift.
- R3: An entry records at most `N_SLOT` (default 4) misses. Listening stops after the last slot fills, and later misses leave it unchanged.
- R4: A second index from an owner whose entry lacks one is stored as the second index and makes that entry the listener again.
- R5: When the listener holds a second index, each miss computes `miss - scale(idx2, s)` and compares it with the recorded candidates. On a match, in the cycle after the miss, `hit_valid_o` pulses with the owner, the base and the shift. The shift is 4-bit two's complement: 2 = 4'h2, 3 = 4'h3, 4 = 4'h4, -3 = 4'hD. The entry is freed and listening stops.
- R6: A match needs equal values under the same shift. Among several matches, the lowest slot wins, then the shift order 2, 3, 4, -3.
- R7: An index from an owner whose entry already holds a second index frees that entry and stops listening. The owner's next index starts over as a first index.
- R8: At most one entry listens. Each allocation or second index moves the listener, and misses are recorded only by the current listener.
- R9: Allocation takes the lowest-numbered free entry. When all entries are in use, it replaces the least recently used entry. Every accepted index event marks its entry as most recently used.
- R10: If an index and a miss arrive in the same cycle while an entry is listening, the miss is handled and the index is dropped. If no entry is listening, the index is handled and the miss has no effect.
- R11: `hit_valid_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_valid_i | input | 1 | An index value is presented this cycle |
| idx_owner_i | input | OWNER_W | Identity of the owning prefetch-table entry |
| idx_value_i | input | IDX_W | Loaded index value, signed |
| miss_valid_i | input | 1 | A cache miss is presented this cycle |
| miss_addr_i | input | ADDR_W | Miss address |
| hit_valid_o | output | 1 | One-cycle pulse: a pattern was confirmed |
| hit_owner_o | output | OWNER_W | Owner of the confirmed pattern |
| hit_base_o | output | ADDR_W | Confirmed base address |
| hit_shift_o | output | 4 | Confirmed shift, two's complement |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit indices, 4-bit owners, four entries and four miss slots per entry. With these values, a fifth owner is enough to force a least-recently-used replacement, and a fifth miss lands just past the slot limit. A 16-bit index such as 0xFFF0 exercises sign extension into the 32-bit address arithmetic. Scenarios that match in several slots or under several shifts at once confirm that the slot/shift priority is observable at the outputs.

// File: rtl/ipat_pkg.sv
package ipat_pkg;
  localparam int N_SHIFT = 4;
  localparam int SHIFT_W = 4;

  // candidate shift list, in priority order
  function automatic int shift_amt(input int k);
    case (k)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      default: return -3;
    endcase
  endfunction

  function automatic logic [SHIFT_W-1:0] shift_code(input int k);
    return SHIFT_W'(shift_amt(k));
  endfunction
endpackage

// File: rtl/ipat_base_gen.sv
module ipat_base_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic [IDX_W-1:0]                            idx_i,
  input  logic [ADDR_W-1:0]                           addr_i,
  output logic [ipat_pkg::N_SHIFT-1:0][ADDR_W-1:0]    base_o
);
  localparam int EXT_W = ADDR_W - IDX_W;

  logic signed [ADDR_W-1:0] sidx;
  assign sidx = {{EXT_W{idx_i[IDX_W-1]}}, idx_i};

  for (genvar k = 0; k < ipat_pkg::N_SHIFT; k++) begin : g_sh
    localparam int SH = ipat_pkg::shift_amt(k);
    logic signed [ADDR_W-1:0] scaled;
    if (SH >= 0) begin : g_left
      assign scaled = sidx <<< SH;
    end else begin : g_right
      assign scaled = sidx >>> (-SH);
    end
    assign base_o[k] = addr_i - scaled;
  end
endmodule

// File: rtl/ipat_match.sv
module ipat_match #(
  parameter int ADDR_W = 32,
  parameter int N_SLOT = 4,
  localparam int NSH   = ipat_pkg::N_SHIFT,
  localparam int CW    = $clog2(N_SLOT + 1),
  localparam int SW    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int HW    = $clog2(NSH)
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [N_SLOT-1:0][NSH-1:0][ADDR_W-1:0]   cand_i,
  input  logic [CW-1:0]                            fill_i,
  input  logic [NSH-1:0][ADDR_W-1:0]               probe_i,
  output logic                                     found_o,
  output logic [SW-1:0]                            slot_o,
  output logic [HW-1:0]                            sel_o
);
  // descending scan: last hit assigned is lowest slot, then lowest shift
  always_comb begin
    found_o = 1'b0;
    slot_o  = '0;
    sel_o   = '0;
    for (int m = N_SLOT - 1; m >= 0; m--) begin
      for (int s = NSH - 1; s >= 0; s--) begin
        if ((CW'(m) < fill_i) && (cand_i[m][s] == probe_i[s])) begin
          found_o = 1'b1;
          slot_o  = SW'(m);
          sel_o   = HW'(s);
        end
      end
    end
  end

  assert_match_in_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (CW'(slot_o) < fill_i));
endmodule

// File: rtl/ipat_lru.sv
module ipat_lru #(
  parameter int N_ENT = 4,
  localparam int EW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [EW-1:0]    touch_idx_i,
  input  logic [N_ENT-1:0] valid_i,
  output logic [EW-1:0]    victim_o
);
  logic [N_ENT-1:0][EW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENT; e++) age_q[e] <= EW'(e);
    end else if (touch_i) begin
      for (int e = 0; e < N_ENT; e++) begin
        if (EW'(e) == touch_idx_i)             age_q[e] <= '0;
        else if (age_q[e] < age_q[touch_idx_i]) age_q[e] <= age_q[e] + 1'b1;
      end
    end
  end

  // free entry first (lowest index), else the oldest
  always_comb begin
    logic got_free;
    got_free = 1'b0;
    victim_o = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (age_q[e] == EW'(N_ENT - 1)) victim_o = EW'(e);
    end
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (!valid_i[e]) begin
        got_free = 1'b1;
        victim_o = EW'(e);
      end
    end
  end

  for (genvar a = 0; a < N_ENT; a++) begin : g_pa
    for (genvar b = a + 1; b < N_ENT; b++) begin : g_pb
      assert_age_distinct_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        age_q[a] != age_q[b]);
    end
  end
endmodule

// File: rtl/ipat_detector.sv
module ipat_detector #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 16,
  parameter int OWNER_W = 4,
  parameter int N_ENT   = 4,
  parameter int N_SLOT  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         idx_valid_i,
  input  logic [OWNER_W-1:0]           idx_owner_i,
  input  logic [IDX_W-1:0]             idx_value_i,
  input  logic                         miss_valid_i,
  input  logic [ADDR_W-1:0]            miss_addr_i,
  output logic                         hit_valid_o,
  output logic [OWNER_W-1:0]           hit_owner_o,
  output logic [ADDR_W-1:0]            hit_base_o,
  output logic [ipat_pkg::SHIFT_W-1:0] hit_shift_o
);
  localparam int NSH = ipat_pkg::N_SHIFT;
  localparam int EW  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int SW  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
  localparam int CW  = $clog2(N_SLOT + 1);
  localparam int HW  = $clog2(NSH);

  typedef logic [NSH-1:0][ADDR_W-1:0] cand_row_t;

  logic [N_ENT-1:0]                    ent_v;
  logic [N_ENT-1:0][OWNER_W-1:0]       ent_tag;
  logic [N_ENT-1:0][IDX_W-1:0]         ent_i1, ent_i2;
  logic [N_ENT-1:0]                    ent_i2set;
  logic [N_ENT-1:0][CW-1:0]            ent_cnt;
  logic [N_ENT-1:0][N_SLOT-1:0]        [NSH-1:0][ADDR_W-1:0] ent_cand;

  logic          trk_valid;
  logic [EW-1:0] trk_ptr;

  // owner lookup
  logic          lk_hit;
  logic [EW-1:0] lk_ptr;
  always_comb begin
    lk_hit = 1'b0;
    lk_ptr = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (!lk_hit && ent_v[e] && ent_tag[e] == idx_owner_i) begin
        lk_hit = 1'b1;
        lk_ptr = EW'(e);
      end
    end
  end

  // miss has priority over index while an entry is listening
  logic do_miss, do_idx;
  assign do_miss = miss_valid_i && trk_valid;
  assign do_idx  = idx_valid_i && !do_miss;

  logic              trk_i2set;
  logic [IDX_W-1:0]  sel_idx;
  logic [CW-1:0]     trk_cnt;
  assign trk_i2set = ent_i2set[trk_ptr];
  assign sel_idx   = trk_i2set ? ent_i2[trk_ptr] : ent_i1[trk_ptr];
  assign trk_cnt   = ent_cnt[trk_ptr];

  cand_row_t probe;
  ipat_base_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_gen (
    .idx_i  (sel_idx),
    .addr_i (miss_addr_i),
    .base_o (probe)
  );

  logic          m_found;
  logic [SW-1:0] m_slot;
  logic [HW-1:0] m_sel;
  ipat_match #(.ADDR_W(ADDR_W), .N_SLOT(N_SLOT)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cand_i  (ent_cand[trk_ptr]),
    .fill_i  (trk_cnt),
    .probe_i (probe),
    .found_o (m_found),
    .slot_o  (m_slot),
    .sel_o   (m_sel)
  );

  logic [EW-1:0] vic_ptr;
  ipat_lru #(.N_ENT(N_ENT)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (do_idx),
    .touch_idx_i (lk_hit ? lk_ptr : vic_ptr),
    .valid_i     (ent_v),
    .victim_o    (vic_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_v       <= '0;
      ent_tag     <= '0;
      ent_i1      <= '0;
      ent_i2      <= '0;
      ent_i2set   <= '0;
      ent_cnt     <= '0;
      ent_cand    <= '0;
      trk_valid   <= 1'b0;
      trk_ptr     <= '0;
      hit_valid_o <= 1'b0;
      hit_owner_o <= '0;
      hit_base_o  <= '0;
      hit_shift_o <= '0;
    end else begin
      hit_valid_o <= 1'b0;
      if (do_miss) begin
        if (!trk_i2set) begin
          if (trk_cnt < CW'(N_SLOT)) begin
            ent_cand[trk_ptr][trk_cnt[SW-1:0]] <= probe;
            ent_cnt[trk_ptr] <= trk_cnt + 1'b1;
          end
          if (trk_cnt + 1'b1 >= CW'(N_SLOT)) trk_valid <= 1'b0;
        end else if (m_found) begin
          hit_valid_o        <= 1'b1;
          hit_owner_o        <= ent_tag[trk_ptr];
          hit_base_o         <= probe[m_sel];
          hit_shift_o        <= ipat_pkg::shift_code(int'(m_sel));
          ent_v[trk_ptr]     <= 1'b0;
          ent_i2set[trk_ptr] <= 1'b0;
          trk_valid          <= 1'b0;
        end
      end else if (do_idx) begin
        if (lk_hit) begin
          if (!ent_i2set[lk_ptr]) begin
            ent_i2[lk_ptr]    <= idx_value_i;
            ent_i2set[lk_ptr] <= 1'b1;
            trk_ptr           <= lk_ptr;
            trk_valid         <= 1'b1;
          end else begin
            ent_v[lk_ptr]     <= 1'b0;
            ent_i2set[lk_ptr] <= 1'b0;
            trk_valid         <= 1'b0;
          end
        end else begin
          ent_v[vic_ptr]     <= 1'b1;
          ent_tag[vic_ptr]   <= idx_owner_i;
          ent_i1[vic_ptr]    <= idx_value_i;
          ent_i2set[vic_ptr] <= 1'b0;
          ent_cnt[vic_ptr]   <= '0;
          trk_ptr            <= vic_ptr;
          trk_valid          <= 1'b1;
        end
      end
    end
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_chk
    assert_slot_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_cnt[e] <= CW'(N_SLOT));
  end

  assert_listener_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trk_valid |-> ent_v[trk_ptr]);

  assert_hit_after_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> $past(miss_valid_i));

  assert_hit_stops_listen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> !trk_valid);

  assert_hit_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |=> !hit_valid_o);

  assert_idx_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_valid_i && miss_valid_i && trk_valid) |=> ($stable(ent_tag) && $stable(ent_i2)));
endmodule

// File: tb/sim_ipat_detector.sv
module sim_ipat_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_valid = 1'b0;
  logic [3:0]  idx_owner = '0;
  logic [15:0] idx_value = '0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        hit_valid;
  logic [3:0]  hit_owner;
  logic [31:0] hit_base;
  logic [3:0]  hit_shift;

  int checks = 0;
  int fails  = 0;
  logic        got_v;
  logic [3:0]  got_o;
  logic [31:0] got_b;
  logic [3:0]  got_s;

  always #2 clk = ~clk;

  ipat_detector u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .idx_valid_i(idx_valid), .idx_owner_i(idx_owner), .idx_value_i(idx_value),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
    .hit_valid_o(hit_valid), .hit_owner_o(hit_owner),
    .hit_base_o(hit_base), .hit_shift_o(hit_shift)
  );

  task automatic sample();
    got_v = hit_valid; got_o = hit_owner; got_b = hit_base; got_s = hit_shift;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; idx_valid = 1'b0; miss_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_idx(input logic [3:0] o, input logic [15:0] v);
    @(negedge clk);
    idx_valid = 1'b1; idx_owner = o; idx_value = v;
    @(negedge clk);
    idx_valid = 1'b0;
    sample();
  endtask

  task automatic send_miss(input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a;
    @(negedge clk);
    miss_valid = 1'b0;
    sample();
  endtask

  task automatic send_both(input logic [3:0] o, input logic [15:0] v, input logic [31:0] a);
    @(negedge clk);
    idx_valid = 1'b1; idx_owner = o; idx_value = v;
    miss_valid = 1'b1; miss_addr = a;
    @(negedge clk);
    idx_valid = 1'b0; miss_valid = 1'b0;
    sample();
  endtask

  task automatic chk(input string req, input logic ev, input logic [3:0] eo,
                     input logic [31:0] eb, input logic [3:0] es);
    checks++;
    if (got_v !== ev || (ev && (got_o !== eo || got_b !== eb || got_s !== es))) begin
      fails++;
      $display("FAIL %s: got v=%0b o=%0h b=%08h s=%0h, exp v=%0b o=%0h b=%08h s=%0h",
               req, got_v, got_o, got_b, got_s, ev, eo, eb, es);
    end
  endtask

  task automatic t_reset();
    do_reset();
    sample();
    chk("R1 reset", 1'b0, 4'h0, 32'h0, 4'h0);
  endtask

  task automatic t_basic();
    do_reset();
    send_idx(4'd3, 16'd5);
    chk("R2 alloc no hit", 1'b0, 4'h0, 32'h0, 4'h0);
    send_miss(32'h1014);
    send_idx(4'd3, 16'd9);
    chk("R4 second index no hit", 1'b0, 4'h0, 32'h0, 4'h0);
    send_miss(32'h1024);
    chk("R5 match shift 2", 1'b1, 4'd3, 32'h1000, 4'h2);
    @(negedge clk); sample();
    chk("R11 pulse ends", 1'b0, 4'h0, 32'h0, 4'h0);
    send_miss(32'h1024);
    chk("R5 entry freed", 1'b0, 4'h0, 32'h0, 4'h0);
  endtask

  task automatic t_neg_shift();
    do_reset();
    send_idx(4'd1, 16'd64);
    send_miss(32'h8008);
    send_idx(4'd1, 16'd128);
    send_miss(32'h8010);
    chk("R2 shift -3", 1'b1, 4'd1, 32'h8000, 4'hD);
    do_reset();
    send_idx(4'd2, 16'hFFF0);
    send_miss(32'h3F80);
    send_idx(4'd2, 16'd4);
    send_miss(32'h4020);
    chk("R2 signed index shift 3", 1'b1, 4'd2, 32'h4000, 4'h3);
  endtask

  task automatic t_priority();
    do_reset();
    send_idx(4'd4, 16'd0);
    send_miss(32'h0300);
    send_idx(4'd4, 16'd0);
    send_miss(32'h0300);
    chk("R6 shift order", 1'b1, 4'd4, 32'h0300, 4'h2);
    do_reset();
    send_idx(4'd4, 16'd1);
    send_miss(32'h0500);
    send_miss(32'h050C);
    send_idx(4'd4, 16'd2);
    send_miss(32'h0510);
    chk("R6 slot before shift", 1'b1, 4'd4, 32'h04F0, 4'h4);
  endtask

  task automatic t_slot_limit();
    do_reset();
    send_idx(4'd5, 16'd1);
    send_miss(32'h1000);
    send_miss(32'h2000);
    send_miss(32'h3000);
    send_miss(32'h4000);
    send_miss(32'h5000);
    send_idx(4'd5, 16'd2);
    send_miss(32'h5004);
    chk("R3 fifth miss not kept", 1'b0, 4'h0, 32'h0, 4'h0);
    send_miss(32'h3004);
    chk("R3 third slot kept", 1'b1, 4'd5, 32'h2FFC, 4'h2);
  endtask

  task automatic t_third_index();
    do_reset();
    send_idx(4'd6, 16'd1);
    send_miss(32'h6000);
    send_idx(4'd6, 16'd2);
    send_miss(32'h7777);
    chk("R7 no match yet", 1'b0, 4'h0, 32'h0, 4'h0);
    send_idx(4'd6, 16'd3);
    send_miss(32'h6004);
    chk("R7 freed, no hit", 1'b0, 4'h0, 32'h0, 4'h0);
    send_idx(4'd6, 16'd1);
    send_miss(32'h6000);
    send_idx(4'd6, 16'd2);
    send_miss(32'h6004);
    chk("R7 restarts as first", 1'b1, 4'd6, 32'h5FFC, 4'h2);
  endtask

  task automatic t_single_listener();
    do_reset();
    send_idx(4'd7, 16'd1);
    send_idx(4'd8, 16'd100);
    send_miss(32'h9000);
    send_idx(4'd7, 16'd2);
    send_miss(32'h9004);
    chk("R8 old listener saw nothing", 1'b0, 4'h0, 32'h0, 4'h0);
    send_idx(4'd8, 16'd101);
    send_miss(32'h9004);
    chk("R8 current listener recorded", 1'b1, 4'd8, 32'h8E70, 4'h2);
  endtask

  task automatic t_lru();
    do_reset();
    send_idx(4'd2, 16'd1);
    send_miss(32'h2000);
    send_idx(4'd3, 16'd10);
    send_idx(4'd4, 16'd20);
    send_idx(4'd1, 16'd30);
    send_idx(4'd5, 16'd40);
    send_idx(4'd2, 16'd2);
    send_miss(32'h2004);
    chk("R9 oldest replaced", 1'b0, 4'h0, 32'h0, 4'h0);
    do_reset();
    send_idx(4'd1, 16'd30);
    send_idx(4'd2, 16'd1);
    send_miss(32'h2000);
    send_idx(4'd3, 16'd10);
    send_idx(4'd4, 16'd20);
    send_idx(4'd5, 16'd40);
    send_idx(4'd2, 16'd2);
    send_miss(32'h2004);
    chk("R9 newer entry kept", 1'b1, 4'd2, 32'h1FFC, 4'h2);
  endtask

  task automatic t_collide();
    do_reset();
    send_idx(4'd9, 16'd1);
    send_both(4'd9, 16'd2, 32'h9000);
    send_idx(4'd9, 16'd2);
    send_miss(32'h9004);
    chk("R10 miss wins, index dropped", 1'b1, 4'd9, 32'h8FFC, 4'h2);
    do_reset();
    send_both(4'd3, 16'd1, 32'h0100);
    send_idx(4'd3, 16'd2);
    send_miss(32'h0104);
    chk("R10 idle miss ignored", 1'b0, 4'h0, 32'h0, 4'h0);
  endtask

  initial begin
    #(4ns * 100000);
    fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_neg_shift();
    t_priority();
    t_slot_limit();
    t_third_index();
    t_single_listener();
    t_lru();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule